// File: doc/BRIEF.md
# Branch Target Buffer with Single-Cycle Flush

This block is a direct-mapped branch target buffer for the first fetch stage of a processor front end. Every cycle the fetch stage presents a word address and gets back, in the same cycle, a hit flag, a predicted target and a two-bit branch kind. When a branch resolves, the back end writes its address, target and kind into the buffer. Entries live in plain storage that has no reset. Their valid bits sit in a separate flip-flop vector, so one flush pulse can empty the whole buffer. The flush is meant for a thread migration or a hard reset.

Two hazards are handled at the lookup itself. First, when a write lands on the entry that is being read in the same cycle, the write data is forwarded to the reader, so the reader never sees a false miss. Second, the following fetch stage may find that a hit pointed at an instruction that is not a branch. It then pulses an invalidate input for that address. The entry is dropped, and a lookup of that entry in the same cycle already reports a miss, so the stale prediction cannot cause further side effects.

Top module: `btb_flush`

## Requirements
- R1: After reset every entry is invalid, and every lookup reports a miss.
- R2: Addresses are word addresses (byte-offset bits are not presented). The entry index is the low IDX_W bits of the word address, and the remaining upper bits are the stored tag. A lookup hits only when the indexed entry is valid and its stored tag equals the tag of the address.
- R3: A write makes its entry valid from the next cycle on. A later lookup of the same address hits with the written target and kind.
- R4: A lookup in the same cycle as a write to the same address hits and returns the new target and kind, whatever the stored entry holds.
- R5: A write to an index that is already in use replaces that entry. The old address then misses and the new address hits. In the cycle of that write, a lookup of the old address still hits with the old data.
- R6: A flush pulse clears every valid bit at the next clock edge. After it, every entry that was not written during the flush misses.
- R7: A lookup in the same cycle as a flush reports a miss, even if a write to the same address is present.
- R8: A write in the same cycle as a flush takes priority for its own entry. That entry is valid after the flush.
- R9: An invalidate pulse clears only the entry its address indexes. All other entries keep their contents. A write to the same entry in the same cycle takes priority, and the entry ends up valid with the written data.
- R10: A lookup in the same cycle as an invalidate of its entry reports a miss, unless a write to the same address in that cycle is forwarded to it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset of the valid bits |
| flush_i | input | 1 | Clears all entries at the next edge |
| inv_en_i | input | 1 | Invalidate request from the next fetch stage (false hit) |
| inv_pc_i | input | PC_W-ALIGN (30) | Word address whose entry is invalidated |
| upd_en_i | input | 1 | Write of a resolved branch |
| upd_pc_i | input | PC_W-ALIGN (30) | Word address of the resolved branch |
| upd_tgt_i | input | PC_W (32) | Target to store |
| upd_type_i | input | TYPE_W (2) | Branch kind to store |
| lk_pc_i | input | PC_W-ALIGN (30) | Fetch word address looked up |
| lk_hit_o | output | 1 | Lookup hit |
| lk_tgt_o | output | PC_W (32) | Predicted target, meaningful on a hit |
| lk_type_o | output | TYPE_W (2) | Predicted branch kind, meaningful on a hit |

## Verification
The bench reads an entry in the same cycle as a write to it. A buffer without forwarding would report a miss there and send fetch down the sequential path. It also reads an address that shares an index with a stored branch but differs in tag. A design that compared the index alone would return the other branch's target. After a flush, it looks up entries that were written before the flush, and one written during it. A design whose valid bits survived would keep predicting stale branches, and one that let the flush win over the write would lose a fresh entry. The invalidate tests confirm that only the named entry is cleared and that a write in the same cycle takes priority.

// File: rtl/btb_flush.sv
module btb_flush #(
  parameter int PC_W   = 32,
  parameter int ALIGN  = 2,
  parameter int IDX_W  = 4,
  parameter int TYPE_W = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  flush_i,
  input  logic                  inv_en_i,
  input  logic [PC_W-1:ALIGN]   inv_pc_i,
  input  logic                  upd_en_i,
  input  logic [PC_W-1:ALIGN]   upd_pc_i,
  input  logic [PC_W-1:0]       upd_tgt_i,
  input  logic [TYPE_W-1:0]     upd_type_i,
  input  logic [PC_W-1:ALIGN]   lk_pc_i,
  output logic                  lk_hit_o,
  output logic [PC_W-1:0]       lk_tgt_o,
  output logic [TYPE_W-1:0]     lk_type_o
);
  localparam int DEPTH = 1 << IDX_W;
  localparam int TLO   = ALIGN + IDX_W;
  localparam int TAG_W = PC_W - TLO;

  logic [DEPTH-1:0]  vld_q;
  logic [TAG_W-1:0]  tag_q [DEPTH];
  logic [PC_W-1:0]   tgt_q [DEPTH];
  logic [TYPE_W-1:0] typ_q [DEPTH];

  logic [IDX_W-1:0] lk_idx, upd_idx, inv_idx;
  logic [TAG_W-1:0] lk_tag, upd_tag;
  logic             stored_hit, fwd;

  assign lk_idx  = lk_pc_i[TLO-1:ALIGN];
  assign upd_idx = upd_pc_i[TLO-1:ALIGN];
  assign inv_idx = inv_pc_i[TLO-1:ALIGN];
  assign lk_tag  = lk_pc_i[PC_W-1:TLO];
  assign upd_tag = upd_pc_i[PC_W-1:TLO];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0;
    end else begin
      if (flush_i)       vld_q          <= '0;
      else if (inv_en_i) vld_q[inv_idx] <= 1'b0;
      if (upd_en_i)      vld_q[upd_idx] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (upd_en_i) begin
      tag_q[upd_idx] <= upd_tag;
      tgt_q[upd_idx] <= upd_tgt_i;
      typ_q[upd_idx] <= upd_type_i;
    end
  end

  assign stored_hit = vld_q[lk_idx] && (tag_q[lk_idx] == lk_tag)
                      && !(inv_en_i && inv_idx == lk_idx);
  assign fwd        = upd_en_i && (upd_idx == lk_idx) && (upd_tag == lk_tag);
  assign lk_hit_o   = !flush_i && (fwd || stored_hit);
  assign lk_tgt_o   = fwd ? upd_tgt_i  : tgt_q[lk_idx];
  assign lk_type_o  = fwd ? upd_type_i : typ_q[lk_idx];

  p_flush_miss_r7: assert property (@(posedge clk) disable iff (!rst_n)
    flush_i |-> !lk_hit_o);

  p_fwd_hit_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_en_i && !flush_i && lk_pc_i == upd_pc_i) |->
      (lk_hit_o && lk_tgt_o == upd_tgt_i && lk_type_o == upd_type_i));

  p_write_visible_r3: assert property (@(posedge clk) disable iff (!rst_n)
    upd_en_i |=> (!(lk_pc_i == $past(upd_pc_i) && !flush_i
                    && !(inv_en_i && inv_pc_i[TLO-1:ALIGN] == lk_pc_i[TLO-1:ALIGN])
                    && !(upd_en_i && upd_pc_i[TLO-1:ALIGN] == lk_pc_i[TLO-1:ALIGN]))
                  || (lk_hit_o && lk_tgt_o == $past(upd_tgt_i))));

  p_flush_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(flush_i) && !$past(upd_en_i) && !upd_en_i) |-> !lk_hit_o);

  p_inv_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(inv_en_i) && !$past(upd_en_i) && !upd_en_i
     && lk_pc_i[TLO-1:ALIGN] == $past(inv_pc_i[TLO-1:ALIGN])) |-> !lk_hit_o);

  p_inv_same_cycle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (inv_en_i && !upd_en_i && inv_pc_i[TLO-1:ALIGN] == lk_pc_i[TLO-1:ALIGN])
      |-> !lk_hit_o);
endmodule

// File: tb/btb_flush_bench.sv
module btb_flush_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        flush_i = 1'b0, inv_en_i = 1'b0, upd_en_i = 1'b0;
  logic [31:0] inv_pc = '0, upd_pc = '0, lk_pc = '0;
  logic [31:0] upd_tgt_i = '0;
  logic [1:0]  upd_type_i = '0;
  logic        lk_hit_o;
  logic [31:0] lk_tgt_o;
  logic [1:0]  lk_type_o;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  btb_flush u_btb_flush (
    .clk, .rst_n, .flush_i, .inv_en_i, .inv_pc_i(inv_pc[31:2]),
    .upd_en_i, .upd_pc_i(upd_pc[31:2]), .upd_tgt_i, .upd_type_i,
    .lk_pc_i(lk_pc[31:2]), .lk_hit_o, .lk_tgt_o, .lk_type_o
  );

  // fields: upd_en, upd_pc, upd_tgt, upd_type, lk_pc, exp_hit, exp_tgt, exp_type
  localparam int NV = 9;
  localparam logic [133:0] VEC [NV] = '{
    {1'b1, 32'h100, 32'h2000, 2'd1, 32'h100, 1'b1, 32'h2000, 2'd1}, // R4 forward
    {1'b0, 32'h0,   32'h0,    2'd0, 32'h100, 1'b1, 32'h2000, 2'd1}, // R3
    {1'b0, 32'h0,   32'h0,    2'd0, 32'h140, 1'b0, 32'h0,    2'd0}, // R2 alias miss
    {1'b1, 32'h140, 32'h3000, 2'd2, 32'h100, 1'b1, 32'h2000, 2'd1}, // R5 old still hits
    {1'b0, 32'h0,   32'h0,    2'd0, 32'h100, 1'b0, 32'h0,    2'd0}, // R5 replaced
    {1'b0, 32'h0,   32'h0,    2'd0, 32'h140, 1'b1, 32'h3000, 2'd2}, // R5 new hits
    {1'b1, 32'h104, 32'h4444, 2'd3, 32'h140, 1'b1, 32'h3000, 2'd2}, // R2 other index
    {1'b0, 32'h0,   32'h0,    2'd0, 32'h104, 1'b1, 32'h4444, 2'd3}, // R3
    {1'b0, 32'h0,   32'h0,    2'd0, 32'h144, 1'b0, 32'h0,    2'd0}  // R2 alias miss
  };

  task automatic chk(input string req, input logic [31:0] pc, input logic eh,
                     input logic [31:0] et, input logic [1:0] ety);
    lk_pc = pc;
    #1;
    checks++;
    if (lk_hit_o !== eh || (eh && (lk_tgt_o !== et || lk_type_o !== ety))) begin
      fails++;
      $display("FAIL %s pc=%h actual hit=%b tgt=%h type=%0d expected hit=%b tgt=%h type=%0d",
               req, pc, lk_hit_o, lk_tgt_o, lk_type_o, eh, et, ety);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    chk("R1", 32'h100, 1'b0, 0, 0);
    chk("R1", 32'h0,   1'b0, 0, 0);
    chk("R1", 32'hFFFFFFFC, 1'b0, 0, 0);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      upd_en_i   = VEC[i][133];
      upd_pc     = VEC[i][132:101];
      upd_tgt_i  = VEC[i][100:69];
      upd_type_i = VEC[i][68:67];
      chk($sformatf("R2-5 row%0d", i), VEC[i][66:35], VEC[i][34], VEC[i][33:2], VEC[i][1:0]);
    end

    // flush with a write in the same cycle
    @(negedge clk);
    flush_i = 1'b1; upd_en_i = 1'b1; upd_pc = 32'h108; upd_tgt_i = 32'h5555; upd_type_i = 2'd0;
    chk("R7", 32'h108, 1'b0, 0, 0);
    chk("R7", 32'h140, 1'b0, 0, 0);
    @(negedge clk);
    flush_i = 1'b0; upd_en_i = 1'b0;
    chk("R6", 32'h140, 1'b0, 0, 0);
    chk("R6", 32'h104, 1'b0, 0, 0);
    chk("R8", 32'h108, 1'b1, 32'h5555, 2'd0);

    // invalidate
    @(negedge clk);
    upd_en_i = 1'b1; upd_pc = 32'h10C; upd_tgt_i = 32'h6666; upd_type_i = 2'd1;
    @(negedge clk);
    upd_pc = 32'h110; upd_tgt_i = 32'h7777; upd_type_i = 2'd2;
    chk("R3", 32'h10C, 1'b1, 32'h6666, 2'd1);
    @(negedge clk);
    upd_en_i = 1'b0; inv_en_i = 1'b1; inv_pc = 32'h10C;
    chk("R10", 32'h10C, 1'b0, 0, 0);
    chk("R9",  32'h110, 1'b1, 32'h7777, 2'd2);
    @(negedge clk);
    inv_en_i = 1'b0;
    chk("R9", 32'h10C, 1'b0, 0, 0);
    chk("R9", 32'h110, 1'b1, 32'h7777, 2'd2);
    chk("R9", 32'h108, 1'b1, 32'h5555, 2'd0);

    // invalidate and write to the same entry together
    @(negedge clk);
    inv_en_i = 1'b1; inv_pc = 32'h110;
    upd_en_i = 1'b1; upd_pc = 32'h110; upd_tgt_i = 32'h8888; upd_type_i = 2'd3;
    chk("R10", 32'h110, 1'b1, 32'h8888, 2'd3);
    @(negedge clk);
    inv_en_i = 1'b0; upd_en_i = 1'b0;
    chk("R9", 32'h110, 1'b1, 32'h8888, 2'd3);

    @(negedge clk);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule